// File: doc/BRIEF.md
# Uncached I/O Error-Field Bridge

This block sits on an uncached memory-mapped I/O path between a TileLink agent and a CHI interconnect. It carries error information across the boundary in both directions. It reports nothing by itself. Any fault it sees is only re-encoded into the fields of the other protocol. The agent further upstream decides what to do about it.

On the receive side, the bridge accepts CHI data beats and dataless CHI responses. Each one becomes a registered TileLink D beat with `denied` and `corrupt` set from:

- the response error code,
- the per-64-bit poison bits,
- a per-byte odd-parity check of the data.

Dataless responses never carry `corrupt`, because the TileLink response types they become require that bit to be clear. On the send side, a TileLink `corrupt` flag and its data combinationally produce the CHI response error code, the poison field and the per-byte check bits.

Top module: `ioErrBridge`

## Requirements
- R1: A received data beat with response error 2'b11 (non-data error) yields a D beat with denied=1 and corrupt=1.
- R2: A received data beat sets corrupt=1, with denied=0, when any of the following holds: the response error is 2'b10 (data error), any poison bit is 1 (poison bit k covers data bits [64k+63:64k]), or any check bit mismatches. Check bit k covers data bits [8k+7:8k], and a byte together with its check bit must hold an odd number of ones.
- R3: A received data beat with response error 2'b00 or 2'b01, no poison and correct check bits yields denied=0 and corrupt=0, and its data is passed on unchanged.
- R4: A dataless response with error code 2'b10 or 2'b11 yields denied=1 and corrupt=0. Codes 2'b00 and 2'b01 yield denied=0 and corrupt=0. Corrupt is never 1 on a dataless D beat.
- R5: The D beat appears on the cycle after the input is accepted, with dValid=1 and dHasData=1 for data or 0 for a response. A cycle with no input gives dValid=0, denied=0 and corrupt=0 on the next cycle.
- R6: If a data beat and a dataless response arrive in the same cycle, the data beat produces the D beat and the response is dropped.
- R7: Combinationally, aCorrupt=1 gives an outgoing response error of 2'b10 with all poison bits 1. aCorrupt=0 gives 2'b00 with all poison bits 0.
- R8: Outgoing check bit k equals the complement of the XOR of data bits [8k+7:8k].
- R9: errReport is 0 at all times.
- R10: During reset dValid, dDenied and dCorrupt are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| rxDatValid | input | 1 | CHI data beat present |
| rxDatRespErr | input | 2 | Data beat error code |
| rxDatPoison | input | DataW/64 | Poison bits, one per 64 data bits |
| rxDatCheck | input | DataW/8 | Received odd-parity check bits |
| rxDatData | input | DataW | Received data |
| rxRspValid | input | 1 | Dataless CHI response present |
| rxRspRespErr | input | 2 | Response error code |
| dValid | output | 1 | TileLink D beat valid |
| dHasData | output | 1 | D beat carries data |
| dData | output | DataW | D beat data |
| dDenied | output | 1 | D beat denied |
| dCorrupt | output | 1 | D beat corrupt |
| aCorrupt | input | 1 | TileLink A-channel corrupt |
| aData | input | DataW | TileLink A-channel data |
| txDatRespErr | output | 2 | Outgoing CHI error code |
| txDatPoison | output | DataW/64 | Outgoing poison bits |
| txDatCheck | output | DataW/8 | Outgoing check bits |
| errReport | output | 1 | Error report line, held low |

## Verification
Two kinds of overlap are provoked:

- **Receive against send.** The receive conversion and the send conversion are fed in the same cycles with unrelated random values. The bench confirms that the combinational send fields depend only on aCorrupt and aData, while the registered D beat depends only on the CHI inputs.
- **Data beat against response.** A data beat and a dataless response are raised together. The bench judges that the D beat follows the data beat's rules (R6), and that no trace of the response's error code reaches denied.

Both overlaps are provoked by random draws and by directed cases that pair opposite error codes on the two receive inputs.

// File: rtl/ioErrBridgePkg.sv
package ioErrBridgePkg;
  typedef enum logic [1:0] {
    RESP_OK    = 2'b00,
    RESP_EXOK  = 2'b01,
    RESP_DERR  = 2'b10,
    RESP_NDERR = 2'b11
  } respErrE;

  // strobes from control to datapath
  typedef struct packed {
    logic load;        // a D beat is produced next cycle
    logic takeData;    // the beat comes from a data beat
    logic setDenied;   // denied value chosen by response rules
    logic codeErr;     // error code alone marks data as corrupt
  } dStrobeT;
endpackage

// File: rtl/ioErrBridgeCtrl.sv
module ioErrBridgeCtrl
  import ioErrBridgePkg::*;
(
  input  logic       rxDatValid,
  input  logic [1:0] rxDatRespErr,
  input  logic       rxRspValid,
  input  logic [1:0] rxRspRespErr,
  output dStrobeT    strb
);
  respErrE datCode;
  respErrE rspCode;

  always_comb begin
    datCode = respErrE'(rxDatRespErr);
    rspCode = respErrE'(rxRspRespErr);
    strb = '0;
    strb.load = rxDatValid | rxRspValid;
    if (rxDatValid) begin
      // data beat wins a same-cycle collision (R6)
      strb.takeData  = 1'b1;
      strb.setDenied = (datCode == RESP_NDERR);
      strb.codeErr   = (datCode == RESP_NDERR) || (datCode == RESP_DERR);
    end else if (rxRspValid) begin
      // dataless: any error maps to denied only (R4)
      strb.setDenied = (rspCode == RESP_NDERR) || (rspCode == RESP_DERR);
    end
  end
endmodule

// File: rtl/ioErrBridgeDatapath.sv
module ioErrBridgeDatapath
  import ioErrBridgePkg::*;
#(
  parameter int DataW = 256
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  dStrobeT              strb,
  input  logic [DataW/64-1:0]  rxDatPoison,
  input  logic [DataW/8-1:0]   rxDatCheck,
  input  logic [DataW-1:0]     rxDatData,
  output logic                 dValid,
  output logic                 dHasData,
  output logic [DataW-1:0]     dData,
  output logic                 dDenied,
  output logic                 dCorrupt,
  input  logic                 aCorrupt,
  input  logic [DataW-1:0]     aData,
  output logic [1:0]           txDatRespErr,
  output logic [DataW/64-1:0]  txDatPoison,
  output logic [DataW/8-1:0]   txDatCheck
);
  localparam int PoisonW = DataW / 64;
  localparam int CheckW  = DataW / 8;

  logic [CheckW-1:0] byteBad;
  logic              checkBad;
  logic              poisonAny;
  logic              corruptNext;

  for (genvar k = 0; k < CheckW; k++) begin : gByte
    // byte plus its check bit must hold an odd count of ones
    assign byteBad[k]    = ~(^{rxDatData[8*k +: 8], rxDatCheck[k]});
    assign txDatCheck[k] = ~(^aData[8*k +: 8]);
  end

  assign checkBad    = |byteBad;
  assign poisonAny   = |rxDatPoison;
  assign corruptNext = strb.takeData & (strb.codeErr | poisonAny | checkBad);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dValid   <= 1'b0;
      dHasData <= 1'b0;
      dData    <= '0;
      dDenied  <= 1'b0;
      dCorrupt <= 1'b0;
    end else begin
      dValid   <= strb.load;
      dHasData <= strb.load & strb.takeData;
      dData    <= strb.takeData ? rxDatData : '0;
      dDenied  <= strb.load & strb.setDenied;
      dCorrupt <= strb.load & corruptNext;
    end
  end

  assign txDatRespErr = aCorrupt ? RESP_DERR : RESP_OK;
  assign txDatPoison  = {PoisonW{aCorrupt}};

  a_r5_load_gives_beat: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> dValid);
  a_r5_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !strb.load |=> (!dValid && !dDenied && !dCorrupt));
  a_r4_dataless_clean: assert property (@(posedge clk) disable iff (!rstN)
    (dValid && !dHasData) |-> !dCorrupt);
  a_r1_denied_has_corrupt: assert property (@(posedge clk) disable iff (!rstN)
    (dValid && dHasData && dDenied) |-> dCorrupt);
  a_r2_poison_marks: assert property (@(posedge clk) disable iff (!rstN)
    (strb.load && strb.takeData && (|rxDatPoison)) |=> dCorrupt);
endmodule

// File: rtl/ioErrBridge.sv
module ioErrBridge
  import ioErrBridgePkg::*;
#(
  parameter int DataW = 256
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 rxDatValid,
  input  logic [1:0]           rxDatRespErr,
  input  logic [DataW/64-1:0]  rxDatPoison,
  input  logic [DataW/8-1:0]   rxDatCheck,
  input  logic [DataW-1:0]     rxDatData,
  input  logic                 rxRspValid,
  input  logic [1:0]           rxRspRespErr,
  output logic                 dValid,
  output logic                 dHasData,
  output logic [DataW-1:0]     dData,
  output logic                 dDenied,
  output logic                 dCorrupt,
  input  logic                 aCorrupt,
  input  logic [DataW-1:0]     aData,
  output logic [1:0]           txDatRespErr,
  output logic [DataW/64-1:0]  txDatPoison,
  output logic [DataW/8-1:0]   txDatCheck,
  output logic                 errReport
);
  dStrobeT strb;

  ioErrBridgeCtrl uCtrl (
    .rxDatValid  (rxDatValid),
    .rxDatRespErr(rxDatRespErr),
    .rxRspValid  (rxRspValid),
    .rxRspRespErr(rxRspRespErr),
    .strb        (strb)
  );

  ioErrBridgeDatapath #(.DataW(DataW)) uDp (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .rxDatPoison (rxDatPoison),
    .rxDatCheck  (rxDatCheck),
    .rxDatData   (rxDatData),
    .dValid      (dValid),
    .dHasData    (dHasData),
    .dData       (dData),
    .dDenied     (dDenied),
    .dCorrupt    (dCorrupt),
    .aCorrupt    (aCorrupt),
    .aData       (aData),
    .txDatRespErr(txDatRespErr),
    .txDatPoison (txDatPoison),
    .txDatCheck  (txDatCheck)
  );

  // R9: errors are only re-encoded, never reported
  assign errReport = 1'b0;
endmodule

// File: tb/ioErrBridge_test.sv
`timescale 1ns/1ps
module ioErrBridge_test;
  localparam int DataW = 256;
  localparam int PW = DataW / 64;
  localparam int CW = DataW / 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rxDatValid = 1'b0;
  logic [1:0] rxDatRespErr = '0;
  logic [PW-1:0] rxDatPoison = '0;
  logic [CW-1:0] rxDatCheck = '0;
  logic [DataW-1:0] rxDatData = '0;
  logic rxRspValid = 1'b0;
  logic [1:0] rxRspRespErr = '0;
  logic dValid, dHasData, dDenied, dCorrupt, errReport;
  logic [DataW-1:0] dData;
  logic aCorrupt = 1'b0;
  logic [DataW-1:0] aData = '0;
  logic [1:0] txDatRespErr;
  logic [PW-1:0] txDatPoison;
  logic [CW-1:0] txDatCheck;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  ioErrBridge #(.DataW(DataW)) uut (.*);

  task automatic check(input string req, input logic [DataW-1:0] act, input logic [DataW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [CW-1:0] goodCheck(input logic [DataW-1:0] d);
    logic [CW-1:0] c;
    for (int k = 0; k < CW; k++) c[k] = ~(^d[8*k +: 8]);
    return c;
  endfunction

  function automatic logic [DataW-1:0] randWide();
    logic [DataW-1:0] v;
    for (int k = 0; k < DataW / 32; k++) v[32*k +: 32] = $urandom;
    return v;
  endfunction

  // drive one cycle, check send side at once and the D beat after the edge
  task automatic step(input bit dv, input logic [1:0] dre, input logic [PW-1:0] pz,
                      input logic [CW-1:0] chk, input logic [DataW-1:0] dat,
                      input bit rv, input logic [1:0] rre,
                      input bit ac, input logic [DataW-1:0] ad);
    logic expDen, expCor;
    string tag;
    @(negedge clk);
    rxDatValid = dv; rxDatRespErr = dre; rxDatPoison = pz; rxDatCheck = chk;
    rxDatData = dat; rxRspValid = rv; rxRspRespErr = rre;
    aCorrupt = ac; aData = ad;
    #1;
    check("R7 respErr", txDatRespErr, ac ? 2'b10 : 2'b00);
    check("R7 poison", txDatPoison, ac ? {PW{1'b1}} : {PW{1'b0}});
    check("R8 check bits", txDatCheck, goodCheck(ad));
    check("R9 errReport", errReport, 0);
    if (dv) begin
      expDen = (dre == 2'b11);
      expCor = dre[1] || (|pz) || (chk != goodCheck(dat));
      tag = rv ? "R6" : (dre == 2'b11 ? "R1" : (expCor ? "R2" : "R3"));
    end else if (rv) begin
      expDen = rre[1];
      expCor = 1'b0;
      tag = "R4";
    end else begin
      expDen = 1'b0;
      expCor = 1'b0;
      tag = "R5";
    end
    @(posedge clk);
    #1;
    check({tag, " valid"}, dValid, dv || rv);
    check({tag, " hasData"}, dHasData, dv);
    check({tag, " denied"}, dDenied, expDen);
    check({tag, " corrupt"}, dCorrupt, expCor);
    if (dv) check({tag, " data"}, dData, dat);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [DataW-1:0] d;
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    #1;
    check("R10 valid", dValid, 0);
    check("R10 denied", dDenied, 0);
    check("R10 corrupt", dCorrupt, 0);
    @(negedge clk);
    rstN = 1'b1;

    d = randWide();
    step(1, 2'b00, '0, goodCheck(d), d, 0, 2'b00, 0, d);          // R3 clean
    step(1, 2'b01, '0, goodCheck(d), d, 0, 2'b00, 1, d);          // R3 exclusive ok
    step(1, 2'b11, '0, goodCheck(d), d, 0, 2'b00, 0, '0);         // R1
    step(1, 2'b10, '0, goodCheck(d), d, 0, 2'b00, 1, '1);         // R2 code
    step(1, 2'b00, 4'b1000, goodCheck(d), d, 0, 2'b00, 0, d);     // R2 poison
    step(1, 2'b00, '0, goodCheck(d) ^ 32'h1, d, 0, 2'b00, 0, d);  // R2 parity
    step(1, 2'b00, '0, goodCheck('0), '0, 0, 2'b00, 0, '0);       // R3 zero data
    step(0, 2'b00, '0, '0, '0, 1, 2'b11, 0, d);                   // R4 nderr
    step(0, 2'b00, '0, '0, '0, 1, 2'b10, 1, d);                   // R4 derr
    step(0, 2'b00, '0, '0, '0, 1, 2'b00, 0, d);                   // R4 ok
    step(0, 2'b00, '0, '0, '0, 0, 2'b11, 0, d);                   // R5 idle
    step(1, 2'b00, '0, goodCheck(d), d, 1, 2'b11, 1, d);          // R6 collision
    step(1, 2'b10, '0, goodCheck(d), d, 1, 2'b00, 0, d);          // R6 collision

    for (int i = 0; i < 400; i++) begin
      logic [DataW-1:0] rd;
      logic [CW-1:0] ck;
      logic [PW-1:0] pz;
      int kind;
      rd = randWide();
      ck = goodCheck(rd);
      if ($urandom_range(0, 3) == 0) ck[$urandom_range(0, CW - 1)] ^= 1'b1;
      pz = '0;
      if ($urandom_range(0, 3) == 0) pz[$urandom_range(0, PW - 1)] = 1'b1;
      kind = $urandom_range(0, 3);
      step(kind[0], 2'($urandom), pz, ck, rd, kind[1], 2'($urandom),
           1'($urandom), randWide());
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule